// File: doc/BRIEF.md
# Sync Word Search and Payload Extractor

The block sits behind a symbol detector and differential decoder. It takes one decoded two-bit symbol (dibit) per strobe, turns it into a bit stream and slides a window along that stream while it looks for a fixed 16-bit synchronization word. When the window matches, the block takes the fixed number of dibits that follow as the payload. It regroups the payload bits into 7-bit characters and presents each character with a one-cycle strobe.

The transmitter sends the frame several times in a row, and the receiver loop may only lock part way through the first copy. For this reason the block returns to searching as soon as the last payload dibit has been taken. Every later copy of the frame is then extracted as well. A pulse marks each word found, and a second pulse, given together with the final character, marks the end of each payload. The defaults are a 1092-dibit payload, which gives 2184 bits or 312 characters, and the sync word 16'h56CB, whose first bits alternate 0/1.

Top module: `sync_payload_extractor`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, char_valid_o, sync_found_o and frame_done_o are 0. After reset the block is searching and its 16-bit window holds all zeros.
- R2: Bit dibit_i[1] of each accepted dibit comes before dibit_i[0] in the bit stream. The window shifts left by two bits for each accepted dibit, so the bit received earliest sits at the MSB. A word sent with the two bits of each dibit swapped is not found.
- R3: While searching, an accepted dibit that makes the window equal SYNC_WORD raises sync_found_o for exactly one cycle. That cycle is the one after the clock edge that accepted the dibit.
- R4: A cycle with dibit_valid_i low changes nothing, whatever value dibit_i carries. Gaps of any length between dibits give the same characters and pulses as a gap-free stream.
- R5: The PAYLOAD_SYMS dibits accepted after the word-completing dibit are payload. Matching is disabled while they are taken, so a copy of the sync word inside the payload raises no sync_found_o.
- R6: Characters are CHAR_BITS wide and assembled MSB first from the payload bits. char_valid_o is high for one cycle, in the cycle after the edge that accepted the dibit carrying the character's last bit. char_o holds the character until the next one arrives.
- R7: A character may start on the second bit of a dibit. char_valid_o is never high in two cycles in a row.
- R8: frame_done_o is high for one cycle, together with char_valid_o for the final (PAYLOAD_SYMS*2/CHAR_BITS-th) character of the payload.
- R9: The block searches again from the dibit right after the last payload dibit. The window keeps the payload's tail bits, so a word completed by the first dibit after a payload is found.
- R10: Back-to-back repeated frames are each found and extracted in full: one sync_found_o, all characters and one frame_done_o per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dibit_i | input | 2 | Decoded symbol; bit 1 comes first in the stream |
| dibit_valid_i | input | 1 | dibit_i is valid this cycle |
| char_o | output | CHAR_BITS | Assembled character, MSB first |
| char_valid_o | output | 1 | char_o carries a new character |
| sync_found_o | output | 1 | Sync word found (one-cycle pulse) |
| frame_done_o | output | 1 | Final character of a payload (one-cycle pulse) |

## Verification
The assertions assume that the payload length in bits is a whole number of characters. They also assume that CHAR_BITS exceeds two, so that at most one character completes per dibit and the last character ends exactly on the last payload dibit. The stimulus keeps the default sizes, which meet both conditions. Otherwise it drives arbitrary values on dibit_i during idle cycles, to show that those values are ignored. Payloads are built so that no stray match in the preamble or at a payload's tail is left to chance. A bench-side model, written from the requirements, gives the expected counts wherever a stream contains deliberate word copies.

// File: rtl/sync_extract_pkg.sv
package sync_extract_pkg;
  typedef enum logic {
    ST_HUNT    = 1'b0,
    ST_CAPTURE = 1'b1
  } ext_state_e;
endpackage

// File: rtl/sx_window.sv
module sx_window #(
  parameter int unsigned         SYNC_BITS = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 16'h56CB
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] dibit_i,
  output logic       match_o
);
  logic [SYNC_BITS-1:0] win_q, win_d;

  assign win_d   = {win_q[SYNC_BITS-3:0], dibit_i};
  assign match_o = valid_i && (win_d == SYNC_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (valid_i) win_q <= win_d;
  end

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(win_q));
endmodule

// File: rtl/sx_frame_ctrl.sv
module sx_frame_ctrl
  import sync_extract_pkg::*;
#(
  parameter int unsigned PAYLOAD_SYMS = 1092
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic match_i,
  output logic start_o,
  output logic capture_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(PAYLOAD_SYMS);

  ext_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign capture_o = (state_q == ST_CAPTURE);
  assign start_o   = (state_q == ST_HUNT) && match_i;
  assign last_o    = capture_o && valid_i && (cnt_q == CNT_W'(PAYLOAD_SYMS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else if (start_o) begin
      state_q <= ST_CAPTURE;
      cnt_q   <= '0;
    end else if (capture_o && valid_i) begin
      if (last_o) begin
        state_q <= ST_HUNT;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> (cnt_q < CNT_W'(PAYLOAD_SYMS)));
  assert_hunt_cnt_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_o |-> (cnt_q == '0));
  assert_capture_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !valid_i) |=> (capture_o && $stable(cnt_q)));
endmodule

// File: rtl/sx_char_packer.sv
module sx_char_packer #(
  parameter int unsigned CHAR_BITS = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 shift_i,
  input  logic [1:0]           dibit_i,
  output logic [CHAR_BITS-1:0] char_o,
  output logic                 char_valid_o
);
  localparam int unsigned NW = $clog2(CHAR_BITS + 1);

  logic [CHAR_BITS-1:0] acc_q, acc_d, ch_d, char_q;
  logic [NW-1:0]        n_q, n_d;
  logic                 emit_d, cv_q;

  // two bits per dibit, high bit first; at most one char completes
  always_comb begin
    acc_d  = acc_q;
    n_d    = n_q;
    emit_d = 1'b0;
    ch_d   = char_q;
    for (int i = 1; i >= 0; i--) begin
      acc_d = {acc_d[CHAR_BITS-2:0], dibit_i[i]};
      n_d   = n_d + 1'b1;
      if (n_d == NW'(CHAR_BITS)) begin
        ch_d   = acc_d;
        emit_d = 1'b1;
        n_d    = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      n_q    <= '0;
      char_q <= '0;
      cv_q   <= 1'b0;
    end else begin
      cv_q <= shift_i && emit_d;
      if (clear_i) begin
        acc_q <= '0;
        n_q   <= '0;
      end else if (shift_i) begin
        acc_q <= acc_d;
        n_q   <= n_d;
        if (emit_d) char_q <= ch_d;
      end
    end
  end

  assign char_o       = char_q;
  assign char_valid_o = cv_q;

  assert_fill_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_q < NW'(CHAR_BITS));
  assert_char_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o);
  assert_char_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(char_o));
endmodule

// File: rtl/sync_payload_extractor.sv
module sync_payload_extractor #(
  parameter int unsigned         SYNC_BITS    = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD    = 16'h56CB,
  parameter int unsigned         PAYLOAD_SYMS = 1092,
  parameter int unsigned         CHAR_BITS    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           dibit_i,
  input  logic                 dibit_valid_i,
  output logic [CHAR_BITS-1:0] char_o,
  output logic                 char_valid_o,
  output logic                 sync_found_o,
  output logic                 frame_done_o
);
  localparam int unsigned PAYLOAD_BITS = PAYLOAD_SYMS * 2;
  localparam int unsigned NUM_CHARS    = PAYLOAD_BITS / CHAR_BITS;
  localparam int unsigned CC_W         = $clog2(NUM_CHARS + 1);

  logic match, start, capture, last;
  logic sync_q, done_q;

  sx_window #(.SYNC_BITS(SYNC_BITS), .SYNC_WORD(SYNC_WORD)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (dibit_valid_i),
    .dibit_i (dibit_i),
    .match_o (match)
  );

  sx_frame_ctrl #(.PAYLOAD_SYMS(PAYLOAD_SYMS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (dibit_valid_i),
    .match_i   (match),
    .start_o   (start),
    .capture_o (capture),
    .last_o    (last)
  );

  sx_char_packer #(.CHAR_BITS(CHAR_BITS)) u_packer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start),
    .shift_i      (capture && dibit_valid_i),
    .dibit_i      (dibit_i),
    .char_o       (char_o),
    .char_valid_o (char_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sync_q <= start;
      done_q <= last;
    end
  end

  assign sync_found_o = sync_q;
  assign frame_done_o = done_q;

  // characters seen since the last sync pulse
  logic [CC_W-1:0] chars_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           chars_seen_q <= '0;
    else if (sync_found_o) chars_seen_q <= '0;
    else if (char_valid_o) chars_seen_q <= chars_seen_q + 1'b1;
  end

  assert_done_with_char_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> char_valid_o);
  assert_done_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (chars_seen_q == CC_W'(NUM_CHARS - 1)));
  assert_no_sync_with_char_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_found_o && char_valid_o));
  assert_sync_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_found_o |=> !sync_found_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: tb/sync_payload_extractor_bench.sv
module sync_payload_extractor_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SYNC = 16'h56CB;
  localparam int PAY = 1092;
  localparam int NCH = 312;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] dibit = '0;
  logic vld = 1'b0;
  logic [6:0] ch;
  logic ch_v, sync_f, done_f;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_payload_extractor u_sync_payload_extractor (
    .clk_i(clk), .rst_ni(rst_n), .dibit_i(dibit), .dibit_valid_i(vld),
    .char_o(ch), .char_valid_o(ch_v), .sync_found_o(sync_f), .frame_done_o(done_f)
  );

  int n_tests = 0, n_fail = 0;
  int sync_cnt, done_cnt, done_orphan, done_misalign;
  logic [6:0] rx_chars[$];
  logic [6:0] exp_chars[$];
  logic [1:0] stream[$];
  int exp_sync, exp_done;

  always @(negedge clk) if (rst_n) begin
    if (ch_v) rx_chars.push_back(ch);
    if (sync_f) sync_cnt++;
    if (done_f) begin
      done_cnt++;
      if (!ch_v) done_orphan++;
      if (rx_chars.size() % NCH != 0) done_misalign++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    vld = 0; dibit = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sync_cnt = 0; done_cnt = 0; done_orphan = 0; done_misalign = 0;
    rx_chars.delete(); stream.delete();
  endtask

  task automatic send_dibit(input logic [1:0] d);
    @(negedge clk); dibit = d; vld = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); vld = 0; dibit = 2'b11; end
  endtask

  function automatic logic [1:0] sync_dibit(input int k);
    return SYNC[15-2*k -: 2];
  endfunction

  function automatic logic [6:0] gen_char(input int k, input int base);
    return 7'((k * 37 + base) & 127);
  endfunction

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) stream.push_back(2'b00);
  endtask

  task automatic push_sync();
    for (int k = 0; k < 8; k++) stream.push_back(sync_dibit(k));
  endtask

  task automatic push_payload(input int base);
    bit bits[$];
    for (int k = 0; k < NCH; k++)
      for (int b = 6; b >= 0; b--) bits.push_back(gen_char(k, base)[b]);
    for (int j = 0; j < PAY; j++) stream.push_back({bits[2*j], bits[2*j+1]});
  endtask

  task automatic send_stream(input bit gaps);
    foreach (stream[i]) begin
      if (gaps) idle(i % 3);
      send_dibit(stream[i]);
    end
    idle(6);
  endtask

  // expected behaviour derived from the requirements
  task automatic run_model();
    logic [15:0] w = '0;
    bit hunt = 1;
    int pos = 0, nb = 0;
    logic [6:0] acc = '0;
    exp_chars.delete(); exp_sync = 0; exp_done = 0;
    foreach (stream[i]) begin
      w = {w[13:0], stream[i]};
      if (hunt) begin
        if (w == SYNC) begin hunt = 0; exp_sync++; pos = 0; nb = 0; end
      end else begin
        for (int b = 1; b >= 0; b--) begin
          acc = {acc[5:0], stream[i][b]};
          nb++;
          if (nb == 7) begin exp_chars.push_back(acc); nb = 0; end
        end
        pos++;
        if (pos == PAY) begin exp_done++; hunt = 1; end
      end
    end
  endtask

  task automatic compare_model(input string req);
    int bad = 0;
    chk(sync_cnt == exp_sync, req, "sync pulses", sync_cnt, exp_sync);
    chk(done_cnt == exp_done, req, "done pulses", done_cnt, exp_done);
    chk(rx_chars.size() == exp_chars.size(), req, "char count", rx_chars.size(), exp_chars.size());
    if (rx_chars.size() == exp_chars.size())
      foreach (rx_chars[i]) if (rx_chars[i] != exp_chars[i]) bad++;
    chk(bad == 0, req, "char mismatches", bad, 0);
  endtask

  task automatic t_reset();
    vld = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    chk(!ch_v && !sync_f && !done_f, "R1", "outputs in reset", {ch_v, sync_f, done_f}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ch_v && !sync_f && !done_f, "R1", "outputs after reset", {ch_v, sync_f, done_f}, 0);
  endtask

  task automatic t_single_frame();
    int bad = 0;
    do_reset();
    push_payload(5);
    for (int i = 0; i < 4; i++) send_dibit(2'b00);
    for (int k = 0; k < 8; k++) send_dibit(sync_dibit(k));
    @(negedge clk); vld = 0;
    chk(sync_f == 1'b1, "R3", "sync pulse one cycle after last word dibit", sync_f, 1);
    @(negedge clk);
    chk(sync_f == 1'b0, "R3", "sync pulse width", sync_f, 0);
    for (int j = 0; j < 4; j++) send_dibit(stream[j]);
    @(negedge clk); vld = 0;
    chk(ch_v == 1'b1 && ch == gen_char(0, 5), "R6", "first char timing/value", ch, gen_char(0, 5));
    @(negedge clk);
    chk(ch_v == 1'b0 && ch == gen_char(0, 5), "R6", "char strobe width and hold", {ch_v, ch}, gen_char(0, 5));
    for (int j = 4; j < PAY; j++) send_dibit(stream[j]);
    idle(6);
    chk(rx_chars.size() == NCH, "R6", "chars per frame", rx_chars.size(), NCH);
    if (rx_chars.size() == NCH) foreach (rx_chars[i]) if (rx_chars[i] != gen_char(i, 5)) bad++;
    chk(bad == 0, "R6", "char values MSB first", bad, 0);
    if (rx_chars.size() > 1)
      chk(rx_chars[1] == gen_char(1, 5), "R7", "char starting mid-dibit", rx_chars[1], gen_char(1, 5));
    chk(done_cnt == 1 && done_orphan == 0 && done_misalign == 0, "R8", "done with final char",
        done_cnt * 100 + done_orphan * 10 + done_misalign, 100);
    chk(sync_cnt == 1, "R3", "sync count", sync_cnt, 1);
  endtask

  task automatic t_gaps();
    int bad = 0;
    do_reset();
    push_zeros(3); push_sync(); push_payload(11);
    send_stream(1);
    chk(sync_cnt == 1 && done_cnt == 1, "R4", "pulses with idle gaps", sync_cnt * 10 + done_cnt, 11);
    chk(rx_chars.size() == NCH, "R4", "chars with idle gaps", rx_chars.size(), NCH);
    if (rx_chars.size() == NCH) foreach (rx_chars[i]) if (rx_chars[i] != gen_char(i, 11)) bad++;
    chk(bad == 0, "R4", "char values with idle gaps", bad, 0);
  endtask

  task automatic t_bit_order();
    do_reset();
    push_zeros(2);
    for (int k = 0; k < 8; k++) begin
      logic [1:0] d = sync_dibit(k);
      stream.push_back({d[0], d[1]});
    end
    push_zeros(40);
    send_stream(0);
    chk(sync_cnt == 0, "R2", "swapped-bit word not found", sync_cnt, 0);
    chk(rx_chars.size() == 0, "R2", "no chars without sync", rx_chars.size(), 0);
  endtask

  task automatic t_sync_in_payload();
    do_reset();
    push_zeros(4); push_sync(); push_payload(23);
    for (int k = 0; k < 8; k++) stream[12 + 100 + k] = sync_dibit(k);
    run_model();
    send_stream(0);
    chk(sync_cnt == 1, "R5", "word inside payload ignored", sync_cnt, 1);
    compare_model("R5");
  endtask

  task automatic t_tail_match();
    do_reset();
    push_zeros(4); push_sync(); push_payload(3);
    for (int k = 0; k < 7; k++) stream[12 + PAY - 7 + k] = sync_dibit(k);
    stream.push_back(sync_dibit(7));
    push_payload(9);
    run_model();
    send_stream(0);
    chk(sync_cnt == 2, "R9", "word completed right after payload", sync_cnt, 2);
    chk(done_cnt == 2, "R9", "second payload extracted", done_cnt, 2);
    compare_model("R9");
  endtask

  task automatic t_repeat();
    int bad = 0;
    do_reset();
    push_zeros(5);
    for (int f = 0; f < 4; f++) begin push_sync(); push_payload(40 + f); end
    send_stream(0);
    chk(sync_cnt == 4, "R10", "sync per repeated frame", sync_cnt, 4);
    chk(done_cnt == 4 && done_misalign == 0, "R10", "done per repeated frame", done_cnt, 4);
    chk(rx_chars.size() == 4 * NCH, "R10", "chars over four frames", rx_chars.size(), 4 * NCH);
    if (rx_chars.size() == 4 * NCH)
      foreach (rx_chars[i]) if (rx_chars[i] != gen_char(i % NCH, 40 + i / NCH)) bad++;
    chk(bad == 0, "R10", "char values over four frames", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single_frame();
    t_gaps();
    t_bit_order();
    t_sync_in_payload();
    t_tail_match();
    t_repeat();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule